// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus with byte-lane strobes. The input clock always passes through a fixed divide-by-32 prescaler. The prescaled ticks feed a counter. The counter's terminal count is a power of two, 2^PS, where PS is a 5-bit field in the control register. Once the watchdog is switched on, software keeps it from expiring by writing a 16-bit magic key into the upper halfword of the control register. Any other write to that halfword does nothing to the count.

When the counter reaches its terminal count, the block raises a single-cycle reset request toward the system reset logic and restarts counting from zero. It also sets a sticky timeout flag in a separate status register. Two further flags in that register record whether the power-state inputs showed idle or sleep at the moment of expiry.

Each register has a plain address, a set alias and a clear alias. A write to an alias changes only the bits written as 1. When the enable bit goes from 1 to 0, the bus interface refuses access for exactly one cycle.

Top module: `keyclr_wdt`

## Requirements
- R1: After reset, the control register reads as zero except bits 7:6, which reflect the `clk_src_sel` input. The status register reads zero, `bus_ready` is high and `wdt_rst_req` is low.
- R2: While control bit 15 (enable) is clear, the counter does not advance and `wdt_rst_req` never asserts.
- R3: With the enable bit set and PS held in control bits 12:8, `wdt_rst_req` first asserts exactly 32·2^PS clock cycles after the edge that accepted the enabling write, and it stays high for one cycle only.
- R4: After an expiry the count restarts from zero, so with no key writes the requests repeat every 32·2^PS cycles.
- R5: A write to word 0 (byte offset 0x00) with strobes 4'b1100 and data bits 31:16 equal to 16'h5743, made while enabled, restarts the count. The next request then comes 32·2^PS cycles after the key's accepting edge.
- R6: A key write has no effect on the count in any of these cases: the upper halfword holds any other value, the strobe pattern is anything other than 4'b1100, or the enable bit is clear.
- R7: A write to the control word at 0x00 changes only strobed lanes. Lane 0 carries bit 0 (windowed-clear flag, read back only). Lane 1 carries bit 15 and bits 12:8. Bits 7:6 are read-only.
- R8: A write to the control set alias (0x04) sets, and a write to the clear alias (0x08) clears, only the writable bits that are 1 in the data.
- R9: The status register (0x10) sets bit 4 at every expiry. It also sets bit 2 if `pwr_idle` is high then, and bit 3 if `pwr_sleep` is high. These bits hold until cleared through the clear alias (0x18). The set alias (0x14) can set them.
- R10: In the cycle right after the enable bit changes from 1 to 0, `bus_ready` is low and any access made in that cycle is ignored. `bus_ready` returns high in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word_addr | input | 3 | Byte address bits 4:2 (word index) |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected |
| bus_ready | output | 1 | Low for the single stall cycle after disabling |
| clk_src_sel | input | 2 | Clock-source selection shown in control bits 7:6 |
| pwr_idle | input | 1 | System is in idle state |
| pwr_sleep | input | 1 | System is in sleep state |
| wdt_rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The hardest condition to create from the ports is the stall cycle, together with proof that an access made inside it is ignored. The bench disables the block through the clear alias. On the next falling edge it checks that `bus_ready` is low. In that same cycle it drives a control write that would re-enable the block with PS at its maximum. It then reads the control register and keeps watching the request output, so a write that had been taken would show up. Expiry timing is checked with a scoreboard. Every enabling write or key write queues the exact cycle at which a request is due. Wrong keys and wrong strobe patterns queue nothing, so if one of them restarted the count, the following request would arrive late and fail the comparison.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // word indices (byte address bits 4:2)
  localparam logic [2:0] IDX_CTRL     = 3'd0;
  localparam logic [2:0] IDX_CTRL_SET = 3'd1;
  localparam logic [2:0] IDX_CTRL_CLR = 3'd2;
  localparam logic [2:0] IDX_STAT     = 3'd4;
  localparam logic [2:0] IDX_STAT_SET = 3'd5;
  localparam logic [2:0] IDX_STAT_CLR = 3'd6;

  // control field positions
  localparam int CTRL_ON_BIT  = 15;
  localparam int CTRL_PS_LSB  = 8;
  localparam int CTRL_SRC_LSB = 6;
  localparam int CTRL_WIN_BIT = 0;

  // status field positions
  localparam int STAT_TMO_BIT   = 4;
  localparam int STAT_SLEEP_BIT = 3;
  localparam int STAT_IDLE_BIT  = 2;

  localparam logic [15:0] CLEAR_KEY  = 16'h5743;
  localparam logic [3:0]  KEY_STROBE = 4'b1100;

  typedef enum logic [1:0] {
    WOP_NONE,
    WOP_WRITE,
    WOP_SET,
    WOP_CLR
  } wr_op_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb begin
    if (!run || restart) pre_d = '0;
    else                 pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = run && (pre_q == {PRE_W{1'b1}});

  // consecutive ticks are impossible when the divider is wider than one
  assert_tick_spaced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int PS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic            tick,
  input  logic [PS_W-1:0] ps,
  output logic            expire,
  output logic            rst_req
);
  localparam int CNT_W = 1 << PS_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_val;
  logic             at_last;

  assign last_val = (CNT_W'(1) << ps) - CNT_W'(1);
  assign at_last  = (cnt_q == last_val);
  assign expire   = run && !restart && tick && at_last;

  always_comb begin
    if (!run || restart)  cnt_d = '0;
    else if (tick)        cnt_d = at_last ? '0 : cnt_q + 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rst_req <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      rst_req <= expire;
    end
  end

  assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_req_needs_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(run));
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int PS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [2:0]      bus_word_addr,
  input  logic [3:0]      bus_be,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            bus_ready,
  input  logic [1:0]      clk_src_sel,
  input  logic            pwr_idle,
  input  logic            pwr_sleep,
  input  logic            expire,
  output logic            ctrl_on,
  output logic [PS_W-1:0] ctrl_ps,
  output logic            key_hit
);
  localparam logic [31:0] PS_MASK  = 32'(((1 << PS_W) - 1) << CTRL_PS_LSB);
  localparam logic [31:0] CTRL_RW  = PS_MASK | (32'd1 << CTRL_ON_BIT) | (32'd1 << CTRL_WIN_BIT);
  localparam logic [31:0] STAT_RW  = (32'd1 << STAT_TMO_BIT) | (32'd1 << STAT_SLEEP_BIT)
                                   | (32'd1 << STAT_IDLE_BIT);

  logic [31:0] ctrl_q, ctrl_d, stat_q, stat_d;
  logic [31:0] lane_m, wmask_c, wmask_s, exp_bits;
  logic        stall_q, stall_d, wr_acc, ctrl_we, stat_we;
  wr_op_e      ctrl_op, stat_op;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lane_m[8*g +: 8] = {8{bus_be[g]}};
  end

  assign bus_ready = !stall_q;
  assign wr_acc    = bus_sel && bus_wr && bus_ready;
  assign wmask_c   = lane_m & CTRL_RW;
  assign wmask_s   = lane_m & STAT_RW;

  always_comb begin
    ctrl_op = WOP_NONE;
    stat_op = WOP_NONE;
    if (wr_acc) begin
      unique case (bus_word_addr)
        IDX_CTRL:     ctrl_op = WOP_WRITE;
        IDX_CTRL_SET: ctrl_op = WOP_SET;
        IDX_CTRL_CLR: ctrl_op = WOP_CLR;
        IDX_STAT:     stat_op = WOP_WRITE;
        IDX_STAT_SET: stat_op = WOP_SET;
        IDX_STAT_CLR: stat_op = WOP_CLR;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (ctrl_op)
      WOP_WRITE: ctrl_d = (ctrl_q & ~wmask_c) | (bus_wdata & wmask_c);
      WOP_SET:   ctrl_d = ctrl_q | (bus_wdata & wmask_c);
      WOP_CLR:   ctrl_d = ctrl_q & ~(bus_wdata & wmask_c);
      default:   ctrl_d = ctrl_q;
    endcase
  end

  assign exp_bits = (32'd1 << STAT_TMO_BIT)
                  | (pwr_idle  ? (32'd1 << STAT_IDLE_BIT)  : 32'd0)
                  | (pwr_sleep ? (32'd1 << STAT_SLEEP_BIT) : 32'd0);

  always_comb begin
    unique case (stat_op)
      WOP_WRITE: stat_d = (stat_q & ~wmask_s) | (bus_wdata & wmask_s);
      WOP_SET:   stat_d = stat_q | (bus_wdata & wmask_s);
      WOP_CLR:   stat_d = stat_q & ~(bus_wdata & wmask_s);
      default:   stat_d = stat_q;
    endcase
    if (expire) stat_d = stat_d | exp_bits;
  end

  assign ctrl_we = (ctrl_op != WOP_NONE);
  assign stat_we = (stat_op != WOP_NONE) || expire;
  assign stall_d = ctrl_q[CTRL_ON_BIT] && !ctrl_d[CTRL_ON_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      stat_q  <= '0;
      stall_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (stat_we) stat_q <= stat_d;
      stall_q <= stall_d;
    end
  end

  assign key_hit = wr_acc && (bus_word_addr == IDX_CTRL) && (bus_be == KEY_STROBE)
                && (bus_wdata[31:16] == CLEAR_KEY) && ctrl_q[CTRL_ON_BIT];
  assign ctrl_on = ctrl_q[CTRL_ON_BIT];
  assign ctrl_ps = ctrl_q[CTRL_PS_LSB +: PS_W];

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (bus_word_addr)
        IDX_CTRL, IDX_CTRL_SET, IDX_CTRL_CLR:
          bus_rdata = ctrl_q | (32'(clk_src_sel) << CTRL_SRC_LSB);
        IDX_STAT, IDX_STAT_SET, IDX_STAT_CLR:
          bus_rdata = stat_q;
        default: ;
      endcase
    end
  end

  assert_stall_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |=> bus_ready);
  assert_stall_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |-> ($past(ctrl_on) && !ctrl_on));
  assert_expiry_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> stat_q[STAT_TMO_BIT]);
endmodule

// File: rtl/keyclr_wdt.sv
module keyclr_wdt #(
  parameter int PRE_W = 5,
  parameter int PS_W  = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_word_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ready,
  input  logic [1:0]  clk_src_sel,
  input  logic        pwr_idle,
  input  logic        pwr_sleep,
  output logic        wdt_rst_req
);
  logic            rst_meta_n, rst_sync_n;
  logic            on, key_hit, tick, expire;
  logic [PS_W-1:0] ps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  wdt_regfile #(.PS_W(PS_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word_addr(bus_word_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .clk_src_sel(clk_src_sel),
    .pwr_idle(pwr_idle), .pwr_sleep(pwr_sleep), .expire(expire),
    .ctrl_on(on), .ctrl_ps(ps), .key_hit(key_hit)
  );

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .run(on), .restart(key_hit), .tick(tick)
  );

  wdt_counter #(.PS_W(PS_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .run(on), .restart(key_hit), .tick(tick),
    .ps(ps), .expire(expire), .rst_req(wdt_rst_req)
  );
endmodule

// File: tb/test_keyclr_wdt.sv
module test_keyclr_wdt;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 20000;
  localparam logic [2:0] A_CTRL = 3'd0, A_CSET = 3'd1, A_CCLR = 3'd2;
  localparam logic [2:0] A_STAT = 3'd4, A_SSET = 3'd5, A_SCLR = 3'd6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_word_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, wdt_rst_req;
  logic [1:0]  clk_src_sel = 2'b10;
  logic        pwr_idle = 1'b0, pwr_sleep = 1'b0;

  int cyc = 0, n_checks = 0, n_fail = 0;
  int exp_q[$];
  bit finished = 0;

  keyclr_wdt i_keyclr_wdt (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word_addr(bus_word_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .clk_src_sel(clk_src_sel),
    .pwr_idle(pwr_idle), .pwr_sleep(pwr_sleep), .wdt_rst_req(wdt_rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops expected request cycles from the scoreboard
  always @(negedge clk) begin
    int e;
    if (rst_n && wdt_rst_req) begin
      if (exp_q.size() == 0) begin
        check("R2/R6 unexpected request", cyc, 0);
      end else begin
        e = exp_q.pop_front();
        check("R3/R4/R5 request cycle", cyc, e);
      end
    end
  end

  // driver tasks start at a falling edge and return at a falling edge
  task automatic bus_write(input logic [2:0] a, input logic [3:0] be,
                           input logic [31:0] d, output int edge_no);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word_addr = a; bus_be = be; bus_wdata = d;
    edge_no = cyc + 1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic bus_read_check(input logic [2:0] a, input logic [31:0] exp, input string req);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_word_addr = a;
    #1 check(req, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_to(input int e);
    while (cyc < e - 1) @(negedge clk);
  endtask

  task automatic expect_req(input int start_edge, input int ps, input int count);
    for (int k = 1; k <= count; k++) exp_q.push_back(start_edge + k * 32 * (1 << ps));
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int ea, ek, es, eb, ec, e1, e2, ed;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 ready", {31'b0, bus_ready}, 32'd1);
    check("R1 request", {31'b0, wdt_rst_req}, 32'd0);
    bus_read_check(A_CTRL, 32'h0000_0080, "R1 ctrl");
    bus_read_check(A_STAT, 32'h0000_0000, "R1 stat");

    // R7 lane-selective writes
    bus_write(A_CTRL, 4'b0001, 32'hFFFF_FFFF, ed);
    bus_read_check(A_CTRL, 32'h0000_0081, "R7 lane0 only");
    bus_write(A_CTRL, 4'b0010, 32'h0000_0200, ed);
    bus_read_check(A_CTRL, 32'h0000_0281, "R7 lane1 PS");
    bus_write(A_CTRL, 4'b0001, 32'h0000_8000, ed);
    bus_read_check(A_CTRL, 32'h0000_0280, "R7 lane0 clears bit0, lane1 untouched");
    // R8 set alias
    bus_write(A_CSET, 4'b1111, 32'h0000_0001, ed);
    bus_read_check(A_CTRL, 32'h0000_0281, "R8 set alias");

    // R2 / R6: disabled, key attempt, no request
    bus_write(A_CTRL, 4'b1100, 32'h5743_0000, ed);
    repeat (300) @(negedge clk);

    // R3 / R4: enable via set alias, PS=2 -> 128 cycles
    bus_write(A_CSET, 4'b1111, 32'h0000_8000, ea);
    expect_req(ea, 2, 2);
    bus_read_check(A_CTRL, 32'h0000_8281, "R8 set alias ON");

    // R5 key restart
    wait_to(ea + 296);
    bus_write(A_CTRL, 4'b1100, 32'h5743_0000, ek);
    expect_req(ek, 2, 1);
    // R6 wrong value and wrong strobes
    wait_to(ek + 50);
    bus_write(A_CTRL, 4'b1100, 32'h1234_0000, ed);
    wait_to(ek + 60);
    bus_write(A_CTRL, 4'b1111, 32'h5743_8281, ed);
    wait_to(ek + 100);
    pwr_idle = 1'b1;
    wait_to(ek + 132);
    pwr_idle = 1'b0;
    // R9 status flags
    bus_read_check(A_STAT, 32'h0000_0014, "R9 timeout+idle");
    bus_write(A_SCLR, 4'b1111, 32'h0000_0004, ed);
    bus_read_check(A_STAT, 32'h0000_0010, "R9 clear alias one bit");
    bus_write(A_SSET, 4'b1111, 32'h0000_0008, ed);
    bus_read_check(A_STAT, 32'h0000_0018, "R9 set alias");
    bus_write(A_SCLR, 4'b1111, 32'h0000_0018, ed);
    bus_read_check(A_STAT, 32'h0000_0000, "R9 cleared");

    // R10 stall after disabling
    wait_to(ek + 160);
    bus_write(A_CCLR, 4'b1111, 32'h0000_8000, es);
    check("R10 stall cycle", {31'b0, bus_ready}, 32'd0);
    bus_write(A_CTRL, 4'b0010, 32'h0000_9F00, ed);
    check("R10 ready back", {31'b0, bus_ready}, 32'd1);
    bus_read_check(A_CTRL, 32'h0000_0281, "R10 stalled write ignored");
    repeat (400) @(negedge clk);

    // R3 / R4 with PS=0 -> 32 cycles
    bus_write(A_CTRL, 4'b0010, 32'h0000_8000, eb);
    expect_req(eb, 0, 3);
    wait_to(eb + 100);
    bus_write(A_CCLR, 4'b1111, 32'h0000_8000, ed);
    @(negedge clk);
    // R6 key while disabled
    bus_write(A_CTRL, 4'b1100, 32'h5743_0000, ed);
    repeat (200) @(negedge clk);

    // R5 repeated keys hold off expiry, PS=3 -> 256 cycles
    bus_write(A_CTRL, 4'b0010, 32'h0000_8300, ec);
    wait_to(ec + 200);
    bus_write(A_CTRL, 4'b1100, 32'h5743_0000, e1);
    wait_to(e1 + 200);
    bus_write(A_CTRL, 4'b1100, 32'h5743_0000, e2);
    expect_req(e2, 3, 1);
    wait_to(e2 + 260);
    bus_write(A_CCLR, 4'b1111, 32'h0000_8000, ed);
    @(negedge clk);
    repeat (50) @(negedge clk);

    check("R3/R5 all expected requests seen", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule